// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a small single-port synchronous memory that takes a new command on every enabled clock edge, with no idle cycle when the traffic switches between reads and writes. Address, chip selects, write enable, byte-lane selects and the burst advance input are all captured on the rising clock edge. A read returns its word in the cycle that follows the capturing edge, straight from the array with no output register. A write takes its data one enabled edge later, so the data bus is busy in the same cycle in which a read would drive it. This keeps the bus full in every cycle.

A clock enable freezes the whole block, so a stalled cycle simply lasts longer. A burst counter steps the two low address bits, in linear or interleaved order, while the advance input is high. The bidirectional data bus is given as separate input, output and output-enable ports. The output enable is driven only during the data cycle of a selected read with the asynchronous output-enable input low.

Top module: `zt_sram`

## Requirements
- R1: Commands are captured on the rising edge of `clk` when `cke_n` is low. A selected read captured at one edge drives `dout` = stored word and `dout_en` = 1 during the following cycle, and a new command may be captured at every edge.
- R2: Write data on `din` is taken at the next enabled edge after the one that captured the write command. A read of the same address captured at that same edge returns the newly written value.
- R3: Byte lane i covers `din`/`dout` bits [8i+7:8i] and is written only when `lane_n[i]` is 0. With `lane_n` all ones the stored word is unchanged.
- R4: An edge with `cke_n` high changes nothing: the array, the pending command and the outputs hold, and `din`, `addr` and the command inputs at that edge are ignored.
- R5: The device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load captured with any other combination is a deselect, and `dout_en` is 0 in the following cycle.
- R6: `dout_en` is 0 during the data cycle of a write, whatever the level of `oe_n`.
- R7: `oe_n` acts without a clock. While it is 1, `dout_en` is 0 and `dout` is 0.
- R8: With `adv`=1 the previous command continues as a burst. Its read or write type is kept, the chip selects and `wr_n` are ignored, and `lane_n` is sampled anew on each beat.
- R9: With `ileave`=0 the burst's low two address bits are (start + beat) mod 4, for beats 0 to 3, and the sequence then wraps.
- R10: With `ileave`=1 the burst's low two address bits are start XOR beat.
- R11: A continue captured while the device is deselected keeps it deselected.
- R12: After reset the device is deselected, with `dout_en`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls every register |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low (on a load only) |
| adv | input | 1 | 1 = continue burst, 0 = load a new command |
| ileave | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_n | input | LANES | Byte-lane write selects, active low |
| addr | input | AW | Word address |
| din | input | LANES*LW | Write data |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| dout | output | LANES*LW | Read data, zero while not driven |
| dout_en | output | 1 | Output-driver enable for the data bus |

## Verification
A read's word and enable are due one enabled edge after the command is captured. A write's data is consumed one enabled edge after its command, so a read-back can appear at the earliest one cycle after that. The bench drives every input at the falling edge. Just before it drives, it checks the outputs that belong to the command captured at the preceding rising edge. It keeps a pending-command record that moves only on enabled edges, so stalled cycles check that the outputs hold. Burst addresses are computed from the start offset and beat number, never read back from the design.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke_n,
  input  logic                sel1_n,
  input  logic                sel2,
  input  logic                sel3_n,
  input  logic                wr_n,
  input  logic                adv,
  input  logic                ileave,
  input  logic [LANES-1:0]    lane_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] din,
  input  logic                oe_n,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_en
);
  localparam int DEPTH = 1 << AW;

  logic             act, wrt;
  logic [AW-3:0]    row;
  logic [1:0]       base, cnt, low;
  logic [LANES-1:0] lmask;
  logic [AW-1:0]    eff;
  logic             sel;

  assign sel     = !sel1_n && sel2 && !sel3_n;
  assign low     = ileave ? (base ^ cnt) : (base + cnt);
  assign eff     = {row, low};
  assign dout_en = act && !wrt && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      wrt   <= 1'b0;
      row   <= '0;
      base  <= '0;
      cnt   <= '0;
      lmask <= '1;
    end else if (!cke_n) begin
      lmask <= lane_n;
      if (!adv) begin
        act  <= sel;
        wrt  <= sel && !wr_n;
        row  <= addr[AW-1:2];
        base <= addr[1:0];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (!cke_n && act && wrt && !lmask[g])
        bank[eff] <= din[g*LW +: LW];
    end
    assign dout[g*LW +: LW] = dout_en ? bank[eff] : '0;
  end
endmodule

module zt_sram_chk #(
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cke_n,
  input logic                sel1_n,
  input logic                sel2,
  input logic                sel3_n,
  input logic                wr_n,
  input logic                adv,
  input logic                oe_n,
  input logic [1:0]          cnt,
  input logic [LANES*LW-1:0] dout,
  input logic                dout_en
);
  assert_oe_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n);

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);

  assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !(!sel1_n && sel2 && !sel3_n)) |=> !dout_en);

  assert_write_cycle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !sel1_n && sel2 && !sel3_n && !wr_n) |=> !dout_en);

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> (oe_n != $past(oe_n)) || ($stable(dout) && $stable(dout_en)));

  assert_beat_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv) |=> cnt == 2'($past(cnt) + 2'd1));

  assert_load_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv) |=> cnt == 2'd0);
endmodule

bind zt_sram zt_sram_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .wr_n(wr_n), .adv(adv), .oe_n(oe_n), .cnt(cnt),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
  logic clk = 1'b0, rst_n = 1'b0, cke_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1, wr_n = 1'b1, adv = 1'b0;
  logic ileave = 1'b0, oe_n = 1'b0;
  logic [1:0]  lane_n = 2'b11;
  logic [5:0]  addr = '0;
  logic [15:0] din = '0, dout;
  logic        dout_en;

  always #10 clk = ~clk;

  zt_sram #(.AW(6), .LANES(2), .LW(8)) dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .wr_n(wr_n), .adv(adv), .ileave(ileave), .lane_n(lane_n),
    .addr(addr), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] model [64];
  logic        p_valid = 0, p_write = 0;
  logic [3:0]  p_row = 0;
  logic [1:0]  p_base = 0, p_cnt = 0, p_lanes = 2'b11;
  string       last_tag = "R12";

  function automatic logic [5:0] p_addr();
    logic [1:0] lo;
    lo = ileave ? (p_base ^ p_cnt) : 2'(p_base + p_cnt);
    return {p_row, lo};
  endfunction

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h0307) ^ 16'hA55A);
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // sk: 0 select, 1 sel1_n high, 2 sel2 low, 3 sel3_n high
  task automatic cyc(input int sk, input logic w, input logic ad, input logic [5:0] a,
                     input logic [1:0] ln, input logic st, input logic [15:0] d,
                     input logic oe, input string tag);
    logic ee;
    @(negedge clk);
    ee = p_valid && !p_write && !oe_n;
    check(last_tag, "dout_en", 16'(dout_en), 16'(ee));
    if (ee) check(last_tag, "dout", dout, model[p_addr()]);
    else    check(last_tag, "dout idle", dout, 16'h0000);
    sel1_n = (sk == 1); sel2 = (sk != 2); sel3_n = (sk == 3);
    wr_n = !w; adv = ad; addr = a; lane_n = ln; cke_n = st; din = d; oe_n = oe;
    last_tag = tag;
    if (!st) begin
      if (p_valid && p_write) begin
        if (!p_lanes[0]) model[p_addr()][7:0]  = d[7:0];
        if (!p_lanes[1]) model[p_addr()][15:8] = d[15:8];
      end
      p_lanes = ln;
      if (!ad) begin
        p_valid = (sk == 0); p_write = (sk == 0) && w;
        p_row = a[5:2]; p_base = a[1:0]; p_cnt = 0;
      end else p_cnt = p_cnt + 2'd1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", "dout_en after reset", 16'(dout_en), 16'h0);
    check("R12", "dout after reset", dout, 16'h0);
    rst_n = 1'b1;
    cyc(1, 0, 0, 0, 2'b11, 0, 0, 0, "R12");

    // back-to-back writes fill every word
    for (int a = 0; a < 64; a++) cyc(0, 1, 0, 6'(a), 2'b00, 0, pat(a + 7), 0, "R2");
    for (int a = 0; a < 64; a++) cyc(0, 0, 0, 6'(a), 2'b00, 0, pat(a + 99), 0, "R1");

    // alternating write / read of the same word, no gap
    for (int i = 0; i < 16; i++) begin
      cyc(0, 1, 0, 6'(i * 4 + 1), 2'b00, 0, 16'h0, 0, "R2");
      cyc(0, 0, 0, 6'(i * 4 + 1), 2'b00, 0, pat(i + 300), 0, "R2");
      cyc(0, 0, 0, 6'(63 - i), 2'b00, 0, 16'hFFFF, 0, "R1");
    end

    // byte lanes
    for (int m = 0; m < 4; m++) begin
      cyc(0, 1, 0, 6'(m + 20), 2'(m), 0, 16'h0, 0, "R3");
      cyc(0, 0, 0, 6'(m + 20), 2'b00, 0, 16'hC3C3 ^ 16'(m), 0, "R3");
    end

    // stalls during a read and during a pending write
    cyc(0, 0, 0, 6'd33, 2'b00, 0, 0, 0, "R4");
    for (int s = 0; s < 3; s++) cyc(0, 1, 0, 6'(s), 2'b00, 1, 16'hDEAD, 0, "R4");
    cyc(0, 1, 0, 6'd34, 2'b00, 0, 0, 0, "R4");
    for (int s = 0; s < 3; s++) cyc(1, 0, 0, 6'(s), 2'b00, 1, 16'hBEEF, 0, "R4");
    cyc(0, 0, 0, 6'd34, 2'b00, 0, 16'h1234, 0, "R4");
    cyc(0, 0, 0, 6'd33, 2'b00, 0, 16'h0, 0, "R4");

    // each chip-select disable, then oe high and write cycles with oe low
    for (int k = 1; k < 4; k++) begin
      cyc(0, 0, 0, 6'(k), 2'b00, 0, 0, 0, "R1");
      cyc(k, 0, 0, 6'(k), 2'b00, 0, 0, 0, "R5");
    end
    cyc(0, 0, 0, 6'd5, 2'b00, 0, 0, 1, "R7");
    cyc(0, 0, 0, 6'd6, 2'b00, 0, 0, 0, "R7");
    cyc(0, 1, 0, 6'd7, 2'b00, 0, 0, 0, "R6");
    cyc(0, 0, 0, 6'd7, 2'b00, 0, 16'h7777, 0, "R6");

    // linear bursts: read from offset 2, then a write burst with varying lanes
    cyc(0, 0, 0, 6'd6, 2'b00, 0, 0, 0, "R9");
    for (int b = 0; b < 6; b++) cyc(b % 4, b % 2, 1, 6'h3F, 2'b00, 0, 0, 0, "R9");
    cyc(0, 1, 0, 6'd9, 2'b00, 0, 0, 0, "R8");
    for (int b = 0; b < 3; b++) cyc(2, 0, 1, 6'h00, 2'(b), 0, pat(b + 500), 0, "R8");
    cyc(0, 0, 0, 6'd9, 2'b00, 0, pat(600), 0, "R8");
    for (int b = 0; b < 3; b++) cyc(0, 1, 1, 6'h00, 2'b00, 0, 0, 0, "R8");

    // interleaved bursts from offsets 3 and 1
    cyc(1, 0, 0, 0, 2'b00, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 2'b00, 0, 0, 0, "R5");
    ileave = 1'b1;
    cyc(0, 0, 0, 6'd27, 2'b00, 0, 0, 0, "R10");
    for (int b = 0; b < 4; b++) cyc(0, 0, 1, 0, 2'b00, 0, 0, 0, "R10");
    cyc(0, 0, 0, 6'd41, 2'b00, 0, 0, 0, "R10");
    for (int b = 0; b < 3; b++) cyc(0, 0, 1, 0, 2'b00, 0, 0, 0, "R10");

    // continue while deselected stays quiet
    cyc(3, 0, 0, 6'd8, 2'b00, 0, 0, 0, "R11");
    for (int b = 0; b < 4; b++) cyc(0, 0, 1, 6'd8, 2'b00, 0, 0, 0, "R11");
    cyc(0, 0, 0, 6'd8, 2'b00, 0, 0, 0, "R1");
    cyc(2, 0, 0, 6'd0, 2'b00, 0, 0, 0, "R5");
    cyc(2, 0, 0, 6'd0, 2'b00, 0, 0, 0, "R5");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule